// File: doc/BRIEF.md
# Dual-Input Capture Time-Difference Timer

This block measures the time between rising edges on two external pulse inputs. A 16-bit counter runs freely and advances only on cycles where a prescaler strobe enables it. The counter is never cleared by a capture. Each pulse input has its own capture register. A rising edge on an input stores the counter value in that input's register and sends a one-cycle interrupt pulse for that channel.

The block gives the difference of the two captures, channel B minus channel A, modulo 2^16. Multiplied by one count period, this is the elapsed time between the two edges. The difference stays correct when the counter wraps once between the captures. Both pulse inputs are asynchronous, so each passes through a two-flop synchronizer before rising-edge detection. A read port with a two-bit address lets the host read the counter, either capture register or the difference.

Top module: `dual_capture_timer`

## Requirements
- R1: A synchronous reset sets the following to zero: the counter, both capture registers, the difference and both interrupt outputs.
- R2: The counter rises by one, modulo 2^16, at each clock edge where countEn is high. It holds its value when countEn is low. Captures never clear it.
- R3: A rising edge on pulseA loads capA with the counter value. The new value appears after the third rising clock edge that follows the input change: two synchronizer flops, then the edge-detect and capture edge.
- R4: irqA is high for exactly one clock cycle for each capture on channel A. That cycle is the first cycle in which capA shows the new value.
- R5: A rising edge on pulseB has the same effect on capB and irqB, with the same latency and pulse form.
- R6: A falling edge on either pulse input causes no capture and no interrupt.
- R7: tickDiff equals capB minus capA, modulo 2^16. This holds when the counter wrapped between the two captures.
- R8: When both inputs rise in the same cycle, both registers take the same counter value and both interrupts pulse in the same cycle.
- R9: A new rising edge on a channel overwrites that channel's capture register. No earlier value is kept.
- R10: rdData is combinational from rdAddr. Address 0 gives the counter, 1 gives capA, 2 gives capB and 3 gives tickDiff.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| countEn | input | 1 | Prescaler strobe that advances the counter |
| pulseA | input | 1 | Asynchronous pulse input, channel A |
| pulseB | input | 1 | Asynchronous pulse input, channel B |
| rdAddr | input | 2 | Read port register select |
| rdData | output | 16 | Selected register value |
| irqA | output | 1 | One-cycle capture pulse, channel A |
| irqB | output | 1 | One-cycle capture pulse, channel B |
| capA | output | 16 | Capture register A |
| capB | output | 16 | Capture register B |
| tickDiff | output | 16 | capB minus capA, modulo 2^16 |

## Verification
The main capture path is tested with the following input patterns. Each one separates a particular fault from correct behaviour.
- An edge on A, a number of known ticks, then an edge on B. This checks that the difference equals the tick count and that the counter was not cleared.
- The same sequence straddling a counter wrap. This separates modulo subtraction from signed or saturating subtraction.
- Both edges in the same cycle. This must give a zero difference and two interrupts that coincide.
- A falling edge followed by a repeated rising edge. These separate a true rising-edge detector from a level-sensitive or any-edge detector, and confirm that a new edge overwrites the register.
- Holding countEn low while captures happen. This shows that the counter advances only on the strobe.

Sampling the interrupt and the capture register cycle by cycle confirms the three-edge latency and that the interrupt lasts exactly one cycle.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef struct packed {
    logic count;
    logic loadA;
    logic loadB;
  } dctStrobes_t;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        countEn,
  input  logic        pulseA,
  input  logic        pulseB,
  output dctStrobes_t strobes
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [NUM_CH-1:0] pulseIn;
  logic [NUM_CH-1:0] riseSeen;

  assign pulseIn = {pulseB, pulseA};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        syncQ <= '0;
        prevQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], pulseIn[ch]};
        prevQ <= syncQ[LAST];
      end
    end

    assign riseSeen[ch] = syncQ[LAST] & ~prevQ;
  end

  always_comb begin
    strobes.count = countEn;
    strobes.loadA = riseSeen[0];
    strobes.loadB = riseSeen[1];
  end
endmodule

// File: rtl/dct_datapath.sv
module dct_datapath
  import dct_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  dctStrobes_t      strobes,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic             irqA,
  output logic             irqB,
  output logic [CNT_W-1:0] capA,
  output logic [CNT_W-1:0] capB,
  output logic [CNT_W-1:0] tickDiff,
  output logic [CNT_W-1:0] counterVal
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      counterVal <= '0;
    end else if (strobes.count) begin
      counterVal <= counterVal + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capA <= '0;
      capB <= '0;
      irqA <= 1'b0;
      irqB <= 1'b0;
    end else begin
      if (strobes.loadA) capA <= counterVal;
      if (strobes.loadB) capB <= counterVal;
      irqA <= strobes.loadA;
      irqB <= strobes.loadB;
    end
  end

  assign tickDiff = capB - capA;

  always_comb begin
    case (rdAddr)
      2'd0:    rdData = counterVal;
      2'd1:    rdData = capA;
      2'd2:    rdData = capB;
      default: rdData = tickDiff;
    endcase
  end
endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
  import dct_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             countEn,
  input  logic             pulseA,
  input  logic             pulseB,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic             irqA,
  output logic             irqB,
  output logic [CNT_W-1:0] capA,
  output logic [CNT_W-1:0] capB,
  output logic [CNT_W-1:0] tickDiff
);
  dctStrobes_t      strobes;
  logic [CNT_W-1:0] counterVal;

  dct_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .countEn (countEn),
    .pulseA  (pulseA),
    .pulseB  (pulseB),
    .strobes (strobes)
  );

  dct_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .irqA       (irqA),
    .irqB       (irqB),
    .capA       (capA),
    .capB       (capB),
    .tickDiff   (tickDiff),
    .counterVal (counterVal)
  );
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             countEn,
  input logic             irqA,
  input logic             irqB,
  input logic [CNT_W-1:0] capA,
  input logic [CNT_W-1:0] capB,
  input logic [CNT_W-1:0] counterVal
);
  // R2: step by one on an enabled cycle
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (countEn && !rst) |=> (counterVal == $past(counterVal) + CNT_W'(1)));

  // R2: hold on a cycle without enable
  a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!countEn && !rst) |=> $stable(counterVal));

  // R4: interrupt A lasts a single cycle
  a_r4_irqa_single: assert property (@(posedge clk) disable iff (rst)
    irqA |=> !irqA);

  // R5: interrupt B lasts a single cycle
  a_r5_irqb_single: assert property (@(posedge clk) disable iff (rst)
    irqB |=> !irqB);

  // R3: capA changes only together with its interrupt
  a_r3_capa_with_irq: assert property (@(posedge clk) disable iff (rst)
    (!$stable(capA) && !$past(rst)) |-> irqA);

  // R5: capB changes only together with its interrupt
  a_r5_capb_with_irq: assert property (@(posedge clk) disable iff (rst)
    (!$stable(capB) && !$past(rst)) |-> irqB);

  // R8: simultaneous captures hold the same value
  a_r8_same_value: assert property (@(posedge clk) disable iff (rst)
    (irqA && irqB) |-> (capA == capB));
endmodule

bind dual_capture_timer dct_checker #(.CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .countEn    (countEn),
  .irqA       (irqA),
  .irqB       (irqB),
  .capA       (capA),
  .capB       (capB),
  .counterVal (counterVal)
);

// File: tb/test_dual_capture_timer.sv
module test_dual_capture_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        countEn = 1'b0;
  logic        pulseA = 1'b0;
  logic        pulseB = 1'b0;
  logic [1:0]  rdAddr = 2'd0;
  logic [15:0] rdData, capA, capB, tickDiff;
  logic        irqA, irqB;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] model = 16'd0;

  dual_capture_timer i_dual_capture_timer (
    .clk(clk), .rst(rst), .countEn(countEn), .pulseA(pulseA), .pulseB(pulseB),
    .rdAddr(rdAddr), .rdData(rdData), .irqA(irqA), .irqB(irqB),
    .capA(capA), .capB(capB), .tickDiff(tickDiff)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic countTicks(int n);
    countEn = 1'b1;
    step(n);
    countEn = 1'b0;
    model = model + 16'(n);
  endtask

  // Drive pulseA and/or pulseB high and follow the capture cycle by cycle.
  task automatic edgeAndWatch(bit doA, bit doB, string req);
    logic [15:0] oldA = capA;
    logic [15:0] oldB = capB;
    if (doA) pulseA = 1'b1;
    if (doB) pulseB = 1'b1;
    step(2);
    check({req, " no early irqA"}, 16'(irqA), 16'd0);
    check({req, " no early irqB"}, 16'(irqB), 16'd0);
    check({req, " capA before latency"}, capA, oldA);
    check({req, " capB before latency"}, capB, oldB);
    step(1);
    check({req, " irqA on capture cycle"}, 16'(irqA), 16'(doA));
    check({req, " irqB on capture cycle"}, 16'(irqB), 16'(doB));
    check({req, " capA value"}, capA, doA ? model : oldA);
    check({req, " capB value"}, capB, doB ? model : oldB);
    step(1);
    check({req, " irqA ends"}, 16'(irqA), 16'd0);
    check({req, " irqB ends"}, 16'(irqB), 16'd0);
  endtask

  task automatic releaseAll(string req);
    int seen = 0;
    logic [15:0] oldA = capA;
    logic [15:0] oldB = capB;
    pulseA = 1'b0;
    pulseB = 1'b0;
    countTicks(3);
    for (int i = 0; i < 5; i++) begin
      step(1);
      if (irqA || irqB) seen++;
    end
    check({req, " falling edge no irq"}, 16'(seen), 16'd0);
    check({req, " falling edge capA kept"}, capA, oldA);
    check({req, " falling edge capB kept"}, capB, oldB);
  endtask

  task automatic testReset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    model = 16'd0;
    check("R1 counter", rdData, 16'd0);
    check("R1 capA", capA, 16'd0);
    check("R1 capB", capB, 16'd0);
    check("R1 diff", tickDiff, 16'd0);
    check("R1 irqs", {14'd0, irqB, irqA}, 16'd0);
  endtask

  task automatic testCountAndHold();
    rdAddr = 2'd0;
    countTicks(37);
    check("R2 counter after ticks", rdData, model);
    step(8);
    check("R2 counter holds without strobe", rdData, model);
  endtask

  task automatic testBasicDiff();
    edgeAndWatch(1'b1, 1'b0, "R3 R4");
    countTicks(25);
    rdAddr = 2'd0;
    check("R2 counter not cleared by capture", rdData, model);
    edgeAndWatch(1'b0, 1'b1, "R5");
    check("R7 diff basic", tickDiff, 16'd25);
    releaseAll("R6");
  endtask

  task automatic testReadPort();
    rdAddr = 2'd0; #1; check("R10 addr0 counter", rdData, model);
    rdAddr = 2'd1; #1; check("R10 addr1 capA", rdData, capA);
    rdAddr = 2'd2; #1; check("R10 addr2 capB", rdData, capB);
    rdAddr = 2'd3; #1; check("R10 addr3 diff", rdData, 16'(capB - capA));
    rdAddr = 2'd0;
  endtask

  task automatic testSimultaneous();
    countTicks(4);
    edgeAndWatch(1'b1, 1'b1, "R8");
    check("R8 diff zero", tickDiff, 16'd0);
    releaseAll("R8 R6");
  endtask

  task automatic testOverwrite();
    logic [15:0] first;
    countTicks(9);
    edgeAndWatch(1'b1, 1'b0, "R9 first");
    first = capA;
    pulseA = 1'b0;
    countTicks(11);
    step(4);
    edgeAndWatch(1'b1, 1'b0, "R9 second");
    check("R9 overwritten value", capA, 16'(first + 16'd11));
    releaseAll("R9 R6");
  endtask

  task automatic testWrap();
    testReset();
    countTicks(65530);
    edgeAndWatch(1'b1, 1'b0, "R7 wrap A");
    check("R7 capA near top", capA, 16'd65530);
    countTicks(10);
    rdAddr = 2'd0;
    check("R2 counter wrapped", rdData, 16'd4);
    edgeAndWatch(1'b0, 1'b1, "R7 wrap B");
    check("R7 diff across wrap", tickDiff, 16'd10);
    rdAddr = 2'd3; #1;
    check("R10 wrap diff on read port", rdData, 16'd10);
    rdAddr = 2'd0;
  endtask

  initial begin
    step(1);
    testReset();
    testCountAndHold();
    testBasicDiff();
    testReadPort();
    testSimultaneous();
    testOverwrite();
    testWrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule